// File: doc/BRIEF.md
# Interrupt Presentation Controller

This block is the per-processor end of a two-level interrupt controller. It keeps exactly one pending interrupt (a source number and its priority), the processor's current priority ceiling, and a software-written inter-processor-interrupt (IPI) priority. It drives a single interrupt line to the processor while something is pending. Numerically lower priorities are more favoured, and 0xFF is the least favoured value, so it acts as "masked".

The source unit offers interrupts as (source number, priority) pairs. A better offer displaces the pending one, and the displaced source is bounced back instead of being queued. The block sends three single-cycle strobes back to the source unit: bounce (reject), done (end-of-interrupt) and a retry request. The processor side has four operations: set the current priority, set the IPI priority, take (accept) and done (end-of-interrupt). The IPI competes for the same single slot under a reserved source number.

The status word is `{current priority[31:24], pending source[23:0]}`, and a source field of zero means that nothing is pending. One operation is handled per cycle. Every strobe and the take result appear registered, one cycle after the operation.

Top module: `intr_present_unit`

## Requirements
- R1: After reset the interrupt line is low, no strobe is active, the pending and IPI priorities are 0xFF, and the status word is zero, so a first take returns 0x00000000.
- R2: An offer whose priority is strictly below the current priority, made while nothing is pending, is latched. One cycle later the line is high, and a later take returns {current priority, offered source}.
- R3: An offer whose priority is greater than or equal to the current priority is bounced, with its own source number, one cycle later. Pending state does not change.
- R4: An offer made while a source is pending with priority less than or equal to the offered one is bounced with the offered source number. The pending source stays.
- R5: A winning offer made while another source is pending bounces the old source number and latches the new one.
- R6: Writing the IPI priority stores it. If the new value is below the current priority and no pending source has priority less than or equal to it, the block bounces any pending source, latches source number IPI_SRC (default 2) with the IPI priority, and raises the line. In all other cases it changes nothing else.
- R7: Take returns the whole status word on take_word with take_ack one cycle later and lowers the line. The status word then becomes {pending priority, 0}.
- R8: Setting a lower current priority while a source is pending, with the new value less than or equal to the pending priority, clears the pending source, lowers the line and bounces that source.
- R9: Setting a current priority greater than or equal to the old one while nothing is pending performs a retry. The retry first latches the IPI if the IPI priority is below the new current priority, and then pulses retry_req.
- R10: Done copies bits 31:24 of the supplied word into the current priority and pulses done_out with bits 23:0. If nothing is pending, it then performs a retry as in R9.
- R11: Operations take precedence in the order take, done, set-current, set-IPI, offer. An offer in the same cycle as any processor operation is neither latched nor bounced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ofr_vld | input | 1 | Offer from the source unit this cycle |
| ofr_src | input | 24 | Offered source number (non-zero) |
| ofr_prio | input | 8 | Offered priority |
| set_cur_vld | input | 1 | Set current priority operation |
| set_cur_prio | input | 8 | New current priority |
| set_ipi_vld | input | 1 | Set IPI priority operation |
| set_ipi_prio | input | 8 | New IPI priority |
| take_vld | input | 1 | Take (accept) operation |
| done_vld | input | 1 | Done (end-of-interrupt) operation |
| done_word | input | 32 | Word supplied with done: priority in 31:24, source in 23:0 |
| irq_o | output | 1 | Interrupt line to the processor |
| take_ack | output | 1 | Take result valid |
| take_word | output | 32 | Status word returned by take |
| bounce_vld | output | 1 | Reject strobe to the source unit |
| bounce_src | output | 24 | Rejected source number |
| done_out_vld | output | 1 | End-of-interrupt strobe to the source unit |
| done_out_src | output | 24 | Source number being ended |
| retry_req | output | 1 | Resend request strobe to the source unit |

## Verification
The bench sweeps every pairing of a small range of current and offered priorities and then runs a long pseudo-random mix of all five operations. A reference model written from the requirements gives the expected outputs. It goes after the equality edges. An offer equal to the current priority must bounce, and a design that used a non-strict compare would latch it. An offer equal to the pending priority must also bounce, and a wrong compare there would displace the pending source with an equal one. Lowering the current priority exactly onto the pending priority must drop the pending source, and an off-by-one compare would leave the line high. It also checks that a take leaves the pending priority as the new ceiling, that a done with nothing pending relatches a still-favoured IPI, and that an offer arriving with a processor operation leaves no trace in later take results.

// File: rtl/intp_pkg.sv
package intp_pkg;
    localparam int DEF_SRC_W   = 24;
    localparam int DEF_PRIO_W  = 8;
    localparam int DEF_IPI_SRC = 2;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_TAKE,
        OP_DONE,
        OP_SETCUR,
        OP_SETIPI,
        OP_OFFER
    } op_e;
endpackage

// File: rtl/intp_prio_judge.sv
// Decides whether a candidate priority may take the single pending slot.
module intp_prio_judge #(
    parameter int PRIO_W = 8
) (
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic [PRIO_W-1:0] ceil_prio,
    input  logic              held_vld,
    input  logic [PRIO_W-1:0] held_prio,
    output logic              wins
);
    assign wins = (cand_prio < ceil_prio) && !(held_vld && (held_prio <= cand_prio));
endmodule

// File: rtl/intr_present_unit.sv
module intr_present_unit #(
    parameter int SRC_W   = intp_pkg::DEF_SRC_W,
    parameter int PRIO_W  = intp_pkg::DEF_PRIO_W,
    parameter int IPI_SRC = intp_pkg::DEF_IPI_SRC
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ofr_vld,
    input  logic [SRC_W-1:0]        ofr_src,
    input  logic [PRIO_W-1:0]       ofr_prio,
    input  logic                    set_cur_vld,
    input  logic [PRIO_W-1:0]       set_cur_prio,
    input  logic                    set_ipi_vld,
    input  logic [PRIO_W-1:0]       set_ipi_prio,
    input  logic                    take_vld,
    input  logic                    done_vld,
    input  logic [PRIO_W+SRC_W-1:0] done_word,
    output logic                    irq_o,
    output logic                    take_ack,
    output logic [PRIO_W+SRC_W-1:0] take_word,
    output logic                    bounce_vld,
    output logic [SRC_W-1:0]        bounce_src,
    output logic                    done_out_vld,
    output logic [SRC_W-1:0]        done_out_src,
    output logic                    retry_req
);
    import intp_pkg::*;

    localparam int WORD_W   = PRIO_W + SRC_W;
    localparam int N_JUDGE  = 3;
    localparam int J_OFFER  = 0;
    localparam int J_IPIWR  = 1;
    localparam int J_RETRY  = 2;
    localparam logic [PRIO_W-1:0] PRIO_MASKED = '1;
    localparam logic [SRC_W-1:0]  IPI_NUM     = SRC_W'(IPI_SRC);

    typedef struct packed {
        logic [PRIO_W-1:0] cur_prio;
        logic [SRC_W-1:0]  pend_src;
        logic [PRIO_W-1:0] pend_prio;
        logic [PRIO_W-1:0] ipi_prio;
        logic              irq;
        logic              take_ack;
        logic [WORD_W-1:0] take_word;
        logic              bounce_vld;
        logic [SRC_W-1:0]  bounce_src;
        logic              done_vld;
        logic [SRC_W-1:0]  done_src;
        logic              retry;
    } state_t;

    state_t s_d, s_q;
    op_e    op_sel;
    logic   pend_vld;
    logic [PRIO_W-1:0] retry_ceil;

    logic [PRIO_W-1:0] j_cand [N_JUDGE];
    logic [PRIO_W-1:0] j_ceil [N_JUDGE];
    logic              j_hvld [N_JUDGE];
    logic [N_JUDGE-1:0] j_win;

    assign pend_vld   = (s_q.pend_src != '0);
    assign retry_ceil = done_vld ? done_word[WORD_W-1:SRC_W] : set_cur_prio;

    // Processor operations win over the source unit; one handled per cycle.
    always_comb begin
        if (take_vld)         op_sel = OP_TAKE;
        else if (done_vld)    op_sel = OP_DONE;
        else if (set_cur_vld) op_sel = OP_SETCUR;
        else if (set_ipi_vld) op_sel = OP_SETIPI;
        else if (ofr_vld)     op_sel = OP_OFFER;
        else                  op_sel = OP_IDLE;
    end

    assign j_cand[J_OFFER] = ofr_prio;
    assign j_ceil[J_OFFER] = s_q.cur_prio;
    assign j_hvld[J_OFFER] = pend_vld;
    assign j_cand[J_IPIWR] = set_ipi_prio;
    assign j_ceil[J_IPIWR] = s_q.cur_prio;
    assign j_hvld[J_IPIWR] = pend_vld;
    assign j_cand[J_RETRY] = s_q.ipi_prio;
    assign j_ceil[J_RETRY] = retry_ceil;
    assign j_hvld[J_RETRY] = 1'b0;   // retry only runs with an empty slot

    for (genvar g = 0; g < N_JUDGE; g++) begin : g_judge
        intp_prio_judge #(.PRIO_W(PRIO_W)) u_judge (
            .cand_prio (j_cand[g]),
            .ceil_prio (j_ceil[g]),
            .held_vld  (j_hvld[g]),
            .held_prio (s_q.pend_prio),
            .wins      (j_win[g])
        );
    end

    always_comb begin
        s_d            = s_q;
        s_d.take_ack   = 1'b0;
        s_d.take_word  = '0;
        s_d.bounce_vld = 1'b0;
        s_d.bounce_src = '0;
        s_d.done_vld   = 1'b0;
        s_d.done_src   = '0;
        s_d.retry      = 1'b0;
        unique case (op_sel)
            OP_TAKE: begin
                s_d.take_ack  = 1'b1;
                s_d.take_word = {s_q.cur_prio, s_q.pend_src};
                s_d.cur_prio  = s_q.pend_prio;
                s_d.pend_src  = '0;
                s_d.irq       = 1'b0;
            end
            OP_DONE: begin
                s_d.cur_prio = done_word[WORD_W-1:SRC_W];
                s_d.done_vld = 1'b1;
                s_d.done_src = done_word[SRC_W-1:0];
                if (!pend_vld) begin
                    s_d.retry = 1'b1;
                    if (j_win[J_RETRY]) begin
                        s_d.pend_src  = IPI_NUM;
                        s_d.pend_prio = s_q.ipi_prio;
                        s_d.irq       = 1'b1;
                    end
                end
            end
            OP_SETCUR: begin
                s_d.cur_prio = set_cur_prio;
                if (set_cur_prio < s_q.cur_prio) begin
                    if (pend_vld && (set_cur_prio <= s_q.pend_prio)) begin
                        s_d.pend_src   = '0;
                        s_d.irq        = 1'b0;
                        s_d.bounce_vld = 1'b1;
                        s_d.bounce_src = s_q.pend_src;
                    end
                end else if (!pend_vld) begin
                    s_d.retry = 1'b1;
                    if (j_win[J_RETRY]) begin
                        s_d.pend_src  = IPI_NUM;
                        s_d.pend_prio = s_q.ipi_prio;
                        s_d.irq       = 1'b1;
                    end
                end
            end
            OP_SETIPI: begin
                s_d.ipi_prio = set_ipi_prio;
                if (j_win[J_IPIWR]) begin
                    s_d.bounce_vld = pend_vld;
                    s_d.bounce_src = pend_vld ? s_q.pend_src : '0;
                    s_d.pend_src   = IPI_NUM;
                    s_d.pend_prio  = set_ipi_prio;
                    s_d.irq        = 1'b1;
                end
            end
            OP_OFFER: begin
                if (j_win[J_OFFER]) begin
                    s_d.bounce_vld = pend_vld;
                    s_d.bounce_src = pend_vld ? s_q.pend_src : '0;
                    s_d.pend_src   = ofr_src;
                    s_d.pend_prio  = ofr_prio;
                    s_d.irq        = 1'b1;
                end else begin
                    s_d.bounce_vld = 1'b1;
                    s_d.bounce_src = ofr_src;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.pend_prio <= PRIO_MASKED;
            s_q.ipi_prio  <= PRIO_MASKED;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq_o        = s_q.irq;
    assign take_ack     = s_q.take_ack;
    assign take_word    = s_q.take_word;
    assign bounce_vld   = s_q.bounce_vld;
    assign bounce_src   = s_q.bounce_src;
    assign done_out_vld = s_q.done_vld;
    assign done_out_src = s_q.done_src;
    assign retry_req    = s_q.retry;

    // R2
    irq_tracks_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.irq == (s_q.pend_src != '0));

    // R7
    take_drops_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_vld |=> (!irq_o && take_ack));

    // R3
    offer_floor_bounce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_OFFER && ofr_prio >= s_q.cur_prio)
        |=> (bounce_vld && bounce_src == $past(ofr_src) && $stable(s_q.pend_src)));

    // R10
    done_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_vld && !take_vld) |=> (done_out_vld && done_out_src == $past(done_word[SRC_W-1:0])));

    // R8
    ceiling_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_SETCUR && set_cur_prio < s_q.cur_prio && pend_vld
         && set_cur_prio <= s_q.pend_prio) |=> (!irq_o && bounce_vld));

    // R11
    offer_shadowed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ofr_vld && (take_vld || set_cur_vld || set_ipi_vld) && !done_vld)
        |=> (!bounce_vld || bounce_src != $past(ofr_src) || $past(ofr_src) == $past(s_q.pend_src)));
endmodule

// File: tb/sim_intr_present_unit.sv
module sim_intr_present_unit;
    localparam int IPI = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ofr_vld = 0, set_cur_vld = 0, set_ipi_vld = 0, take_vld = 0, done_vld = 0;
    logic [23:0] ofr_src = '0;
    logic [7:0]  ofr_prio = '0, set_cur_prio = '0, set_ipi_prio = '0;
    logic [31:0] done_word = '0;
    logic        irq_o, take_ack, bounce_vld, done_out_vld, retry_req;
    logic [31:0] take_word;
    logic [23:0] bounce_src, done_out_src;

    int n_chk = 0, n_bad = 0;

    // reference state
    logic [7:0]  m_cur = 8'h00, m_pend = 8'hFF, m_ipi = 8'hFF;
    logic [23:0] m_src = '0;

    always #10 clk = ~clk;

    intr_present_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .ofr_vld(ofr_vld), .ofr_src(ofr_src), .ofr_prio(ofr_prio),
        .set_cur_vld(set_cur_vld), .set_cur_prio(set_cur_prio),
        .set_ipi_vld(set_ipi_vld), .set_ipi_prio(set_ipi_prio),
        .take_vld(take_vld), .done_vld(done_vld), .done_word(done_word),
        .irq_o(irq_o), .take_ack(take_ack), .take_word(take_word),
        .bounce_vld(bounce_vld), .bounce_src(bounce_src),
        .done_out_vld(done_out_vld), .done_out_src(done_out_src),
        .retry_req(retry_req)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one set of operations; the model computes the expected strobes.
    task automatic run_op(input logic a, input logic e, input logic c, input logic i,
                          input logic o, input logic [31:0] ew, input logic [7:0] cv,
                          input logic [7:0] iv, input logic [7:0] op, input logic [23:0] os,
                          input string force_tag);
        logic xb = 0, xd = 0, xr = 0, xa = 0;
        logic [23:0] xbs = '0, xds = '0;
        logic [31:0] xw = '0;
        logic retry_run = 0;
        string tag = "R11";
        take_vld = a; done_vld = e; set_cur_vld = c; set_ipi_vld = i; ofr_vld = o;
        done_word = ew; set_cur_prio = cv; set_ipi_prio = iv; ofr_prio = op; ofr_src = os;
        if (a) begin
            tag = "R7"; xa = 1; xw = {m_cur, m_src}; m_cur = m_pend; m_src = '0;
        end else if (e) begin
            tag = "R10"; m_cur = ew[31:24]; xd = 1; xds = ew[23:0]; retry_run = (m_src == 0);
        end else if (c) begin
            if (cv < m_cur) begin
                tag = "R8";
                if (m_src != 0 && cv <= m_pend) begin
                    xb = 1; xbs = m_src; m_src = '0;
                end
            end else begin
                tag = "R9"; retry_run = (m_src == 0);
            end
            m_cur = cv;
        end else if (i) begin
            tag = "R6"; m_ipi = iv;
            if (iv < m_cur && !(m_src != 0 && m_pend <= iv)) begin
                if (m_src != 0) begin xb = 1; xbs = m_src; end
                m_src = IPI; m_pend = iv;
            end
        end else if (o) begin
            if (op >= m_cur) begin
                tag = "R3"; xb = 1; xbs = os;
            end else if (m_src != 0 && m_pend <= op) begin
                tag = "R4"; xb = 1; xbs = os;
            end else begin
                tag = (m_src != 0) ? "R5" : "R2";
                if (m_src != 0) begin xb = 1; xbs = m_src; end
                m_src = os; m_pend = op;
            end
        end
        if (retry_run) begin
            xr = 1;
            if (m_ipi < m_cur) begin m_src = IPI; m_pend = m_ipi; end
        end
        if (force_tag != "") tag = force_tag;
        @(posedge clk);
        @(negedge clk);
        take_vld = 0; done_vld = 0; set_cur_vld = 0; set_ipi_vld = 0; ofr_vld = 0;
        chk(tag, {take_ack, take_ack ? take_word : 32'h0, bounce_vld, bounce_vld ? bounce_src : 24'h0,
                  done_out_vld, retry_req, irq_o},
                 {xa, xw, xb, xbs, xd, xr, (m_src != 0)});
        if (xd) chk(tag, {40'h0, done_out_src}, {40'h0, xds});
    endtask

    task automatic offer(input logic [7:0] p, input logic [23:0] s, input string t);
        run_op(0, 0, 0, 0, 1, 0, 0, 0, p, s, t);
    endtask
    task automatic setcur(input logic [7:0] v, input string t);
        run_op(0, 0, 1, 0, 0, 0, v, 0, 0, 0, t);
    endtask
    task automatic setipi(input logic [7:0] v, input string t);
        run_op(0, 0, 0, 1, 0, 0, 0, v, 0, 0, t);
    endtask
    task automatic take(input string t);
        run_op(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, t);
    endtask
    task automatic done(input logic [31:0] w, input string t);
        run_op(0, 1, 0, 0, 0, w, 0, 0, 0, 0, t);
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports, then the status word via take
        chk("R1", {take_ack, bounce_vld, done_out_vld, retry_req, irq_o}, 5'b0);
        take("R1");

        // directed
        setcur(8'hFF, "R9");
        offer(8'd5, 24'h10, "R2");
        offer(8'd7, 24'h11, "R4");
        offer(8'd3, 24'h12, "R5");
        offer(8'd3, 24'h13, "R4");
        offer(8'hFF, 24'h14, "R4");
        setipi(8'd4, "R6");
        setipi(8'd1, "R6");
        take("R7");
        take("R7");
        done(32'hFF00_0002, "R10");
        take("R7");
        setipi(8'hFF, "R6");
        done(32'hFF00_0002, "R10");
        offer(8'd9, 24'h20, "R2");
        setcur(8'd9, "R8");
        setcur(8'h20, "R9");
        setipi(8'h10, "R6");
        take("R7");
        run_op(0, 0, 1, 0, 1, 0, 8'h30, 0, 8'd1, 24'h55, "R11");
        take("R11");
        run_op(0, 0, 0, 1, 1, 0, 0, 8'hFF, 8'd1, 24'h56, "R11");
        take("R11");
        done(32'h0500_0002, "R10");
        offer(8'd5, 24'h21, "R3");

        // sweep: ceiling x offered priority
        for (int c = 0; c < 16; c++) begin
            for (int p = 0; p < 16; p++) begin
                setcur(8'(c), "");
                offer(8'(p), 24'(16'h100 + p), "");
                take("");
                done({8'(c), 24'(16'h100 + p)}, "");
            end
        end

        // pseudo-random mix over a small priority range
        for (int k = 0; k < 4000; k++) begin
            logic [7:0] pv;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pv = (lfsr[11:8] == 4'hF) ? 8'hFF : {4'h0, lfsr[11:8]};
            case (lfsr[2:0])
                3'd0: take("");
                3'd1: done({pv, 24'(lfsr[7:4] + 1)}, "");
                3'd2: setcur(pv, "");
                3'd3: setipi(pv, "");
                3'd4: run_op(lfsr[12], 0, lfsr[13], 0, 1, 0, pv, 0, 8'(lfsr[6:3]),
                             24'(lfsr[7:4] + 16), "");
                default: offer(8'(lfsr[6:3]), 24'(lfsr[7:4] + 16), "");
            endcase
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule